// File: doc/BRIEF.md
# Parallel Float-to-Integer Convert and Register Store Unit

This block is the execute stage for one paired instruction that does two things at once. The convert half reads a 32-bit floating-point word from memory through an indirect address. It rounds the value toward negative infinity to a 32-bit two's-complement integer and writes the result to one of eight registers. The store half writes the contents of one of those eight registers to a second indirect address. Each indirect address is an auxiliary register plus a displacement of 0, 1, or the value of one of two index registers.

Both halves see the machine state as it was when the instruction issued. The register value being stored is taken before the convert half writes its destination. The memory word being converted is read before the store half writes its address. The memory port is synchronous with one cycle of read latency. The read address goes out in the issue cycle, and both writes (register and memory) are presented together in the next cycle. A value too large for the integer range saturates toward the side it overflowed, and a status flag marks that write.

The register file, the memory and the hazards between consecutive instructions belong to the surrounding pipeline.

Top module: `f2i_store_exec`

## Requirements
- R1: An instruction is accepted only when `issue` is high and the word has bits 31:26 = 110101, bit 6 = 0, bits 2:0 = 000, and zero in the reserved bits 22:20 and 14:12. Any other word raises neither `memRdEn` in that cycle nor `rfWrEn`/`memWrEn` in the next.
- R2: The convert destination is bits 25:23. The convert source field is bits 22:15. The store destination field is bits 14:7. The store source register is bits 5:3 and is driven on `rdSel`.
- R3: Each 8-bit indirect field holds an auxiliary register number in bits 2:0 and a displacement select in bits 4:3. The select codes are 00 for 0, 01 for 1, 10 for `idx0` and 11 for `idx1`. The effective address is the auxiliary register plus the displacement, modulo 2^ADDR_W.
- R4: The float input has a two's-complement exponent e in bits 31:24, a sign in bit 23 and a fraction f in bits 22:0. Its value is ±(1 + f/2^23)·2^e. The written integer is the floor of that value.
- R5: An exponent of -128 (0x80) converts to 0 whatever the sign and fraction are, and it does not raise `ovfFlag`.
- R6: A value above 2^31-1 writes 0x7FFFFFFF, and a value below -2^31 writes 0x80000000; both raise `ovfFlag` with the write. The exact value -2^31 writes 0x80000000 with `ovfFlag` low.
- R7: The store writes the register value sampled in the issue cycle, even when its register is the convert destination.
- R8: When both indirect addresses are equal, the conversion uses the memory contents from before the store.
- R9: `memRdEn` and `memRdAddr` are valid in the issue cycle. `rfWrEn` and `memWrEn` are high together for exactly the following cycle, carrying the store address and data from the issue cycle.
- R10: During reset, `rfWrEn`, `memWrEn` and `ovfFlag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| issue | input | 1 | Instruction word presented for execution this cycle |
| instrWord | input | 32 | Instruction word |
| rdSel | output | 3 | Register file read select for the store source |
| rdData | input | DATA_W | Register file read data for `rdSel` |
| auxRegs | input | NUM_AR*ADDR_W | Auxiliary registers, register k in bits k*ADDR_W upward |
| idx0 | input | ADDR_W | First index register |
| idx1 | input | ADDR_W | Second index register |
| memRdEn | output | 1 | Memory read request |
| memRdAddr | output | ADDR_W | Memory read address (convert source) |
| memRdData | input | DATA_W | Memory read data, one cycle after the request |
| rfWrEn | output | 1 | Register write enable |
| rfWrSel | output | 3 | Register write select |
| rfWrData | output | DATA_W | Converted integer |
| ovfFlag | output | 1 | Conversion saturated, valid with `rfWrEn` |
| memWrEn | output | 1 | Memory write enable |
| memWrAddr | output | ADDR_W | Memory write address (store destination) |
| memWrData | output | DATA_W | Stored register value |

## Verification
On every cycle, the assertions check the write timing against the read request, the rejection of malformed words, that the stored data and the written register number come from the issue cycle, the zero encoding, and that a saturated write always carries one of the two limit values. The rounding toward negative infinity, the exact -2^31 exception, the address arithmetic for every displacement select, and the read-before-write order at a shared address can only be shown by the bench's scenarios. The bench compares memory and register contents after each instruction against a real-number reference.

// File: rtl/f2i_store_pkg.sv
package f2i_store_pkg;

  localparam logic [5:0] OPC_PATTERN = 6'b110101;
  localparam int         REG_SEL_W   = 3;
  localparam int         FP_W        = 32;

  typedef enum logic [1:0] {
    DISP_ZERO = 2'b00,
    DISP_ONE  = 2'b01,
    DISP_IDX0 = 2'b10,
    DISP_IDX1 = 2'b11
  } disp_sel_e;

  typedef struct packed {
    disp_sel_e      disp;
    logic [2:0]     aux;
  } ind_sel_t;

  typedef struct packed {
    logic [2:0]     rsvd;
    ind_sel_t       sel;
  } ind_field_t;

  typedef struct packed {
    logic [5:0]           opc;
    logic [REG_SEL_W-1:0] cvtDst;
    ind_field_t           cvtSrc;
    ind_field_t           stDst;
    logic                 zeroA;
    logic [REG_SEL_W-1:0] stSrc;
    logic [2:0]           zeroB;
  } insn_t;

  typedef struct packed {
    logic [REG_SEL_W-1:0] cvtDst;
    ind_sel_t             cvtSrc;
    ind_sel_t             stDst;
    logic [REG_SEL_W-1:0] stSrc;
  } dec_t;

  typedef struct packed {
    logic capture;
    logic commit;
  } strobe_t;

endpackage

// File: rtl/f2i_store_conv.sv
module f2i_store_conv #(
  parameter int DATA_W = 32
) (
  input  logic [31:0]       fpIn,
  output logic [DATA_W-1:0] intOut,
  output logic              ovf
);
  localparam int MANT_W = 24;
  localparam int WIDE_W = MANT_W + DATA_W - 1;
  localparam int SH_W   = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] INT_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] INT_MIN = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic signed [7:0] OVF_EXP  = 8'(DATA_W - 1);
  localparam logic signed [7:0] ZERO_EXP = 8'sh80;

  logic signed [7:0]   expS;
  logic                sgn;
  logic [22:0]         frac;
  logic [WIDE_W-1:0]   wide;
  logic [DATA_W-1:0]   mag;
  logic                fracNz;

  always_comb begin
    expS   = $signed(fpIn[31:24]);
    sgn    = fpIn[23];
    frac   = fpIn[22:0];
    wide   = {{(DATA_W-1){1'b0}}, 1'b1, frac} << expS[SH_W-1:0];
    mag    = wide[WIDE_W-1:MANT_W-1];
    fracNz = |wide[MANT_W-2:0];
    ovf    = 1'b0;
    if (expS == ZERO_EXP) begin
      intOut = '0;
    end else if (expS >= OVF_EXP) begin
      if (sgn && (expS == OVF_EXP) && (frac == '0)) begin
        intOut = INT_MIN;
      end else begin
        ovf    = 1'b1;
        intOut = sgn ? INT_MIN : INT_MAX;
      end
    end else if (expS < 0) begin
      intOut = sgn ? '1 : '0;
    end else if (sgn) begin
      intOut = '0 - (mag + DATA_W'(fracNz));
    end else begin
      intOut = mag;
    end
  end
endmodule

// File: rtl/f2i_store_agu.sv
module f2i_store_agu
  import f2i_store_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int NUM_AR = 8
) (
  input  ind_sel_t                   sel,
  input  logic [NUM_AR*ADDR_W-1:0]   auxRegs,
  input  logic [ADDR_W-1:0]          idx0,
  input  logic [ADDR_W-1:0]          idx1,
  output logic [ADDR_W-1:0]          ea
);
  localparam int AR_SEL_W = $clog2(NUM_AR);

  logic [ADDR_W-1:0] arArr [NUM_AR];
  logic [ADDR_W-1:0] disp;

  for (genvar g = 0; g < NUM_AR; g++) begin : g_unpack
    assign arArr[g] = auxRegs[g*ADDR_W +: ADDR_W];
  end

  always_comb begin
    unique case (sel.disp)
      DISP_ZERO: disp = '0;
      DISP_ONE:  disp = ADDR_W'(1);
      DISP_IDX0: disp = idx0;
      DISP_IDX1: disp = idx1;
      default:   disp = '0;
    endcase
    ea = arArr[sel.aux[AR_SEL_W-1:0]] + disp;
  end
endmodule

// File: rtl/f2i_store_ctrl.sv
module f2i_store_ctrl
  import f2i_store_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        issue,
  input  logic [31:0] instrWord,
  output dec_t        dec,
  output strobe_t     strobe
);
  insn_t insn;
  logic  wordOk;
  logic  execValid;

  always_comb begin
    insn   = insn_t'(instrWord);
    wordOk = (insn.opc == OPC_PATTERN) && !insn.zeroA && (insn.zeroB == 3'b000)
             && (insn.cvtSrc.rsvd == 3'b000) && (insn.stDst.rsvd == 3'b000);
    dec.cvtDst = insn.cvtDst;
    dec.cvtSrc = insn.cvtSrc.sel;
    dec.stDst  = insn.stDst.sel;
    dec.stSrc  = insn.stSrc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) execValid <= 1'b0;
    else       execValid <= issue && wordOk;
  end

  assign strobe.capture = issue && wordOk;
  assign strobe.commit  = execValid;
endmodule

// File: rtl/f2i_store_dpath.sv
module f2i_store_dpath
  import f2i_store_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24,
  parameter int NUM_AR = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strobe,
  input  dec_t                       dec,
  input  logic [DATA_W-1:0]          rdData,
  input  logic [NUM_AR*ADDR_W-1:0]   auxRegs,
  input  logic [ADDR_W-1:0]          idx0,
  input  logic [ADDR_W-1:0]          idx1,
  input  logic [DATA_W-1:0]          memRdData,
  output logic [ADDR_W-1:0]          memRdAddr,
  output logic [REG_SEL_W-1:0]       rfWrSel,
  output logic [DATA_W-1:0]          rfWrData,
  output logic                       ovfFlag,
  output logic [ADDR_W-1:0]          memWrAddr,
  output logic [DATA_W-1:0]          memWrData
);
  localparam int NUM_PORTS = 2;

  ind_sel_t             selArr [NUM_PORTS];
  logic [ADDR_W-1:0]    eaArr  [NUM_PORTS];
  logic [REG_SEL_W-1:0] dstQ;
  logic [ADDR_W-1:0]    stAddrQ;
  logic [DATA_W-1:0]    stDataQ;
  logic [DATA_W-1:0]    convOut;
  logic                 convOvf;

  assign selArr[0] = dec.cvtSrc;
  assign selArr[1] = dec.stDst;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_agu
    f2i_store_agu #(.ADDR_W(ADDR_W), .NUM_AR(NUM_AR)) u_agu (
      .sel     (selArr[p]),
      .auxRegs (auxRegs),
      .idx0    (idx0),
      .idx1    (idx1),
      .ea      (eaArr[p])
    );
  end

  // snapshot of every source taken in the issue cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dstQ    <= '0;
      stAddrQ <= '0;
      stDataQ <= '0;
    end else if (strobe.capture) begin
      dstQ    <= dec.cvtDst;
      stAddrQ <= eaArr[1];
      stDataQ <= rdData;
    end
  end

  f2i_store_conv #(.DATA_W(DATA_W)) u_conv (
    .fpIn   (memRdData[31:0]),
    .intOut (convOut),
    .ovf    (convOvf)
  );

  assign memRdAddr = eaArr[0];
  assign rfWrSel   = dstQ;
  assign rfWrData  = strobe.commit ? convOut : '0;
  assign ovfFlag   = strobe.commit && convOvf;
  assign memWrAddr = stAddrQ;
  assign memWrData = stDataQ;
endmodule

// File: rtl/f2i_store_exec.sv
module f2i_store_exec
  import f2i_store_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24,
  parameter int NUM_AR = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       issue,
  input  logic [31:0]                instrWord,
  output logic [2:0]                 rdSel,
  input  logic [DATA_W-1:0]          rdData,
  input  logic [NUM_AR*ADDR_W-1:0]   auxRegs,
  input  logic [ADDR_W-1:0]          idx0,
  input  logic [ADDR_W-1:0]          idx1,
  output logic                       memRdEn,
  output logic [ADDR_W-1:0]          memRdAddr,
  input  logic [DATA_W-1:0]          memRdData,
  output logic                       rfWrEn,
  output logic [2:0]                 rfWrSel,
  output logic [DATA_W-1:0]          rfWrData,
  output logic                       ovfFlag,
  output logic                       memWrEn,
  output logic [ADDR_W-1:0]          memWrAddr,
  output logic [DATA_W-1:0]          memWrData
);
  dec_t    dec;
  strobe_t strobe;

  f2i_store_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .issue     (issue),
    .instrWord (instrWord),
    .dec       (dec),
    .strobe    (strobe)
  );

  f2i_store_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_AR(NUM_AR)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .dec       (dec),
    .rdData    (rdData),
    .auxRegs   (auxRegs),
    .idx0      (idx0),
    .idx1      (idx1),
    .memRdData (memRdData),
    .memRdAddr (memRdAddr),
    .rfWrSel   (rfWrSel),
    .rfWrData  (rfWrData),
    .ovfFlag   (ovfFlag),
    .memWrAddr (memWrAddr),
    .memWrData (memWrData)
  );

  assign rdSel   = dec.stSrc;
  assign memRdEn = strobe.capture;
  assign rfWrEn  = strobe.commit;
  assign memWrEn = strobe.commit;
endmodule

// File: rtl/f2i_store_chk.sv
module f2i_store_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              issue,
  input logic              wordLegal,
  input logic [2:0]        dstField,
  input logic [DATA_W-1:0] rdData,
  input logic              memRdEn,
  input logic [DATA_W-1:0] memRdData,
  input logic              rfWrEn,
  input logic [2:0]        rfWrSel,
  input logic [DATA_W-1:0] rfWrData,
  input logic              ovfFlag,
  input logic              memWrEn,
  input logic [DATA_W-1:0] memWrData
);
  localparam logic [DATA_W-1:0] INT_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] INT_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  // R9
  wr_follows_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> (rfWrEn && memWrEn));

  // R9
  wr_needs_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rfWrEn || memWrEn) |-> $past(memRdEn));

  // R1
  reject_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(issue && wordLegal) |-> (!memRdEn ##1 (!rfWrEn && !memWrEn)));

  // R2
  dst_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issue && wordLegal) |=> (rfWrSel == $past(dstField)));

  // R7
  store_snapshot_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (memWrData == $past(rdData)));

  // R6
  ovf_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |-> (rfWrEn && ((rfWrData == INT_MAX) || (rfWrData == INT_MIN))));

  // R5
  zero_exp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rfWrEn && (memRdData[31:24] == 8'h80)) |-> ((rfWrData == '0) && !ovfFlag));

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (!rfWrEn && !memWrEn && !ovfFlag));
endmodule

bind f2i_store_exec f2i_store_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .issue     (issue),
  .wordLegal ((instrWord[31:26] == 6'b110101) && (instrWord[22:20] == 3'b000) &&
              (instrWord[14:12] == 3'b000) && !instrWord[6] && (instrWord[2:0] == 3'b000)),
  .dstField  (instrWord[25:23]),
  .rdData    (rdData),
  .memRdEn   (memRdEn),
  .memRdData (memRdData),
  .rfWrEn    (rfWrEn),
  .rfWrSel   (rfWrSel),
  .rfWrData  (rfWrData),
  .ovfFlag   (ovfFlag),
  .memWrEn   (memWrEn),
  .memWrData (memWrData)
);

// File: tb/f2i_store_exec_tb.sv
module f2i_store_exec_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 24;
  localparam int NUM_AR = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issue = 1'b0;
  logic [31:0] instrWord = '0;
  logic [2:0] rdSel;
  logic [DATA_W-1:0] rdData;
  logic [NUM_AR*ADDR_W-1:0] auxRegs;
  logic [ADDR_W-1:0] idx0 = '0, idx1 = '0;
  logic memRdEn, rfWrEn, ovfFlag, memWrEn;
  logic [ADDR_W-1:0] memRdAddr, memWrAddr;
  logic [DATA_W-1:0] memRdData = '0, rfWrData, memWrData;
  logic [2:0] rfWrSel;

  logic [31:0] mem [256];
  logic [31:0] regs [8];
  logic [ADDR_W-1:0] aux [NUM_AR];

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NUM_AR; i++) auxRegs[i*ADDR_W +: ADDR_W] = aux[i];
  end
  assign rdData = regs[rdSel];

  // bench memory (read-first) and register file models
  always @(posedge clk) begin
    if (memRdEn) memRdData <= mem[memRdAddr[7:0]];
    if (memWrEn) mem[memWrAddr[7:0]] <= memWrData;
    if (rfWrEn) regs[rfWrSel] <= rfWrData;
  end

  f2i_store_exec #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_AR(NUM_AR)) u_dut (
    .clk(clk), .rstN(rstN), .issue(issue), .instrWord(instrWord),
    .rdSel(rdSel), .rdData(rdData), .auxRegs(auxRegs), .idx0(idx0), .idx1(idx1),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .rfWrEn(rfWrEn), .rfWrSel(rfWrSel), .rfWrData(rfWrData), .ovfFlag(ovfFlag),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // real-number reference for the conversion
  task automatic refConv(input logic [31:0] w, output logic [31:0] r, output logic o);
    int e;
    real v;
    e = int'($signed(w[31:24]));
    if (e == -128) begin
      r = '0; o = 1'b0;
    end else begin
      v = (1.0 + real'(int'(w[22:0])) / 8388608.0) * (2.0 ** e);
      if (w[23]) v = -v;
      v = $floor(v);
      if (v > 2147483647.0) begin
        r = 32'h7FFF_FFFF; o = 1'b1;
      end else if (v < -2147483648.0) begin
        r = 32'h8000_0000; o = 1'b1;
      end else begin
        r = 32'(longint'(v)); o = 1'b0;
      end
    end
  endtask

  function automatic logic [ADDR_W-1:0] eaOf(input logic [7:0] f);
    logic [ADDR_W-1:0] d;
    case (f[4:3])
      2'b00: d = '0;
      2'b01: d = ADDR_W'(1);
      2'b10: d = idx0;
      default: d = idx1;
    endcase
    return aux[f[2:0]] + d;
  endfunction

  function automatic logic [31:0] mkWord(input logic [2:0] dst, input logic [7:0] s2,
                                         input logic [7:0] d2, input logic [2:0] s3);
    return {6'b110101, dst, s2, d2, 1'b0, s3, 3'b000};
  endfunction

  function automatic logic [31:0] mkFp(input int e, input bit s, input logic [22:0] f);
    return {8'(e), s, f};
  endfunction

  task automatic randEnv();
    for (int i = 0; i < NUM_AR; i++) aux[i] = ADDR_W'($urandom_range(0, 150));
    idx0 = ADDR_W'($urandom_range(0, 40));
    idx1 = ADDR_W'($urandom_range(0, 40));
    for (int i = 0; i < 8; i++) regs[i] = $urandom;
  endtask

  task automatic runVec(input logic [2:0] dst, input logic [7:0] s2, input logic [7:0] d2,
                        input logic [2:0] s3, input logic [31:0] fp);
    logic [ADDR_W-1:0] ea0, ea1;
    logic [31:0] expInt, expStore;
    logic expOvf;
    @(negedge clk);
    ea0 = eaOf(s2);
    ea1 = eaOf(d2);
    mem[ea0[7:0]] = fp;
    expStore = regs[s3];
    refConv(fp, expInt, expOvf);
    instrWord = mkWord(dst, s2, d2, s3);
    issue = 1'b1;
    #1;
    chk("R9 memRdEn in issue cycle", 32'(memRdEn), 32'd1);
    chk("R3 read address", 32'(memRdAddr), 32'(ea0));
    chk("R2 store source select", 32'(rdSel), 32'(s3));
    @(negedge clk);
    issue = 1'b0;
    chk("R9 rfWrEn next cycle", 32'(rfWrEn), 32'd1);
    chk("R9 memWrEn next cycle", 32'(memWrEn), 32'd1);
    chk("R2 write select", 32'(rfWrSel), 32'(dst));
    chk("R4 converted value", rfWrData, expInt);
    chk("R6 overflow flag", 32'(ovfFlag), 32'(expOvf));
    chk("R3 store address", 32'(memWrAddr), 32'(ea1));
    chk("R7 store data is issue-cycle value", memWrData, expStore);
    @(negedge clk);
    chk("R9 write strobes one cycle", 32'({rfWrEn, memWrEn}), 32'd0);
    chk("R8 memory after store", mem[ea1[7:0]], expStore);
    chk("R4 register after write", regs[dst], expInt);
  endtask

  task automatic runBad(input logic [31:0] w, input logic en);
    @(negedge clk);
    instrWord = w;
    issue = en;
    #1;
    chk("R1 no read request", 32'(memRdEn), 32'd0);
    @(negedge clk);
    issue = 1'b0;
    chk("R1 no write strobes", 32'({rfWrEn, memWrEn}), 32'd0);
  endtask

  initial begin
    logic [2:0] dst, s3;
    logic [7:0] s2, d2;
    logic [31:0] fp;
    void'($urandom(32'd7741));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    randEnv();
    repeat (3) @(negedge clk);
    chk("R10 rfWrEn in reset", 32'(rfWrEn), 32'd0);
    chk("R10 memWrEn in reset", 32'(memWrEn), 32'd0);
    chk("R10 ovfFlag in reset", 32'(ovfFlag), 32'd0);
    rstN = 1'b1;

    // R4 rounding toward negative infinity
    runVec(3'd1, 8'h02, 8'h05, 3'd4, mkFp(0, 0, 23'd0));
    runVec(3'd2, 8'h0B, 8'h13, 3'd5, mkFp(0, 1, 23'h400000));
    runVec(3'd3, 8'h04, 8'h1E, 3'd6, mkFp(-1, 0, 23'h000000));
    runVec(3'd4, 8'h06, 8'h01, 3'd7, mkFp(-1, 1, 23'h000000));
    runVec(3'd5, 8'h17, 8'h0A, 3'd0, mkFp(1, 0, 23'h700000));
    runVec(3'd6, 8'h01, 8'h02, 3'd1, mkFp(30, 0, 23'h7FFFFF));
    runVec(3'd7, 8'h1B, 8'h03, 3'd2, mkFp(30, 1, 23'h7FFFFF));
    // R5 zero encoding
    runVec(3'd0, 8'h03, 8'h07, 3'd3, mkFp(-128, 1, 23'h000123));
    // R6 saturation and the exact most negative value
    runVec(3'd1, 8'h05, 8'h0E, 3'd2, mkFp(31, 0, 23'd0));
    runVec(3'd2, 8'h0D, 8'h10, 3'd3, mkFp(31, 1, 23'd0));
    runVec(3'd3, 8'h14, 8'h09, 3'd4, mkFp(31, 1, 23'd1));
    runVec(3'd4, 8'h1F, 8'h00, 3'd5, mkFp(127, 0, 23'h2AAAAA));
    // R7 store source equals convert destination
    runVec(3'd6, 8'h02, 8'h0C, 3'd6, mkFp(5, 0, 23'h100000));
    // R8 shared address
    runVec(3'd5, 8'h12, 8'h12, 3'd1, mkFp(4, 1, 23'h0F0000));
    // R1 malformed words and idle issue
    runBad({6'b110100, 26'h0}, 1'b1);
    runBad(mkWord(3'd1, 8'h02, 8'h03, 3'd2) | 32'h0000_0040, 1'b1);
    runBad(mkWord(3'd1, 8'h02, 8'h03, 3'd2) | 32'h0000_0001, 1'b1);
    runBad(mkWord(3'd1, 8'h22, 8'h03, 3'd2), 1'b1);
    runBad(mkWord(3'd1, 8'h02, 8'h43, 3'd2), 1'b1);
    runBad(mkWord(3'd1, 8'h02, 8'h03, 3'd2), 1'b0);

    for (int n = 0; n < 400; n++) begin
      int cls;
      int e;
      randEnv();
      dst = 3'($urandom);
      s3  = ($urandom_range(0, 4) == 0) ? dst : 3'($urandom);
      s2  = {3'b000, 5'($urandom)};
      d2  = ($urandom_range(0, 5) == 0) ? s2 : {3'b000, 5'($urandom)};
      cls = $urandom_range(0, 9);
      if (cls == 0)      e = -128;
      else if (cls <= 2) e = $urandom_range(31, 40);
      else if (cls <= 7) e = int'($urandom_range(0, 34)) - 3;
      else               e = int'($urandom_range(0, 255)) - 128;
      fp = mkFp(e, 1'($urandom), 23'($urandom));
      runVec(dst, s2, d2, s3, fp);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule